// File: doc/BRIEF.md
# Direct-Mapped Write-Back Cache Controller

This block is a first-level cache that sits between a set of requesters and a slower line-granular memory level. Each line of the cache is chosen by the index field of the word address, so every address has exactly one home line. A line carries a tag, a valid bit and a dirty bit. Writes stay in the cache and only reach the lower level when a dirty line has to make room for another one.

Requesters share a single request port that carries an identifier, an operation, an address and write data. The first requester that shows up while the cache is free takes ownership and keeps it until its access completes. Every cycle the cache answers with one of three codes. On a miss it first writes back a dirty occupant and then fetches the wanted line, with one lower-level handshake at a time. A line that hits still waits a fixed number of cycles before the access completes. Loads and stores act only in the completing cycle.

Top module: `dmc_cache`

## Requirements
- R1: After reset every line is invalid and clean, so the first access to any line misses. With no request presented the response is WAIT and no lower-level request is made.
- R2: Response codes on `rsp` and `mem_rsp` are OK = 0, WAIT = 1, BLOCKED = 2. The value 3 is never produced.
- R3: When the cache is unowned, a presented request claims it for `req_id`. A request from any other identifier gets WAIT and has no effect on the cache or the lower level. Ownership ends in the cycle the owner receives OK.
- R4: On a miss whose line is dirty, the cache issues a lower-level write (`mem_we` = 1) of the whole stored line at address {stored tag, index, zero offset}. The dirty bit clears only in a cycle where `mem_rsp` is OK.
- R5: On a miss whose line is clean, the cache issues a lower-level read at {requested tag, index, zero offset}. It loads `mem_rline` and the new tag only in a cycle where `mem_rsp` is OK.
- R6: While a write-back or refill is pending the response is BLOCKED and the lower-level request is repeated every cycle. A clean miss with an immediate lower level costs one BLOCKED cycle. A dirty miss costs two.
- R7: Once the line hits, the owner sees WAIT for HIT_DELAY cycles and OK on the next. The countdown then reloads, so every hit takes HIT_DELAY+1 cycles.
- R8: `req_op` encodes 0 = read word, 1 = read line, 2 = write word, 3 = write line. The address holds offset in its low bits, index above it and tag at the top.
- R9: A word write stores `req_wword` at the offset and marks the line dirty. A line write stores `req_wline` and marks the line dirty. Word w of a line occupies bits [w*WORD_W +: WORD_W].
- R10: In the OK cycle a read returns the addressed word on `rsp_word` and the whole line on `rsp_line`. A written value is readable by a later access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A requester presents an access |
| req_id | input | ID_W | Identifier of the presenting requester |
| req_op | input | 2 | Operation code |
| req_addr | input | ADDR_W | Word address |
| req_wword | input | WORD_W | Word to store |
| req_wline | input | LINE_W | Line to store |
| rsp | output | 2 | Response code |
| rsp_word | output | WORD_W | Addressed word, valid with OK |
| rsp_line | output | LINE_W | Addressed line, valid with OK |
| mem_req | output | 1 | Lower-level request |
| mem_we | output | 1 | Lower-level direction, 1 = write-back |
| mem_addr | output | ADDR_W | Line-aligned lower-level address |
| mem_wline | output | LINE_W | Line written back |
| mem_rsp | input | 2 | Lower-level response code |
| mem_rline | input | LINE_W | Line returned by the lower level |

## Verification
Two things can land in the same cycle. One is the lower level accepting a write-back or refill. The other is the owner still being shown BLOCKED, because the new tag or the cleared dirty bit only counts from the next cycle. The bench provokes this with an immediate lower level and with a stalled one. It judges the result by the exact number of BLOCKED and total cycles per access, and by the addresses and line contents the memory model captured. A second overlap is a foreign requester arriving while the owner is mid-miss. The bench checks that this requester sees WAIT with no lower-level request in the same cycle, and that the owner's access then completes with the right data.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic [1:0] {
    RSP_OK      = 2'd0,
    RSP_WAIT    = 2'd1,
    RSP_BLOCKED = 2'd2
  } rsp_e;

  typedef enum logic [1:0] {
    OP_RD_WORD = 2'd0,
    OP_RD_LINE = 2'd1,
    OP_WR_WORD = 2'd2,
    OP_WR_LINE = 2'd3
  } op_e;
endpackage

// File: rtl/dmc_owner.sv
module dmc_owner #(
  parameter int ID_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic [ID_W-1:0] req_id,
  input  logic            done,
  output logic            is_mine
);
  logic            owned_q;
  logic [ID_W-1:0] owner_q;

  assign is_mine = req_valid && (!owned_q || req_id == owner_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      owned_q <= 1'b0;
      owner_q <= '0;
    end else if (is_mine && done) begin
      owned_q <= 1'b0;
    end else if (req_valid && !owned_q) begin
      owned_q <= 1'b1;
      owner_q <= req_id;
    end
  end

  // R3: ownership persists with the same identifier until completion
  assert_owner_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (owned_q && !(is_mine && done)) |=> (owned_q && owner_q == $past(owner_q)));

  // R3: completion always frees the cache
  assert_owner_release_R3: assert property (@(posedge clk) disable iff (rst)
    (is_mine && done) |=> !owned_q);
endmodule

// File: rtl/dmc_tags.sv
module dmc_tags #(
  parameter int LINES = 16,
  parameter int TAG_W = 10,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] idx,
  input  logic [TAG_W-1:0] tag_in,
  input  logic             load_tag,
  input  logic             clr_dirty,
  input  logic             set_dirty,
  output logic             hit,
  output logic             dirty,
  output logic [TAG_W-1:0] tag_out
);
  logic [TAG_W-1:0] tag_mem [LINES];
  logic [LINES-1:0] valid_q;
  logic [LINES-1:0] dirty_q;

  assign tag_out = tag_mem[idx];
  assign hit     = valid_q[idx] && (tag_mem[idx] == tag_in);
  assign dirty   = dirty_q[idx];

  always_ff @(posedge clk) begin
    if (load_tag) tag_mem[idx] <= tag_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      if (load_tag)  valid_q[idx] <= 1'b1;
      if (clr_dirty) dirty_q[idx] <= 1'b0;
      else if (set_dirty) dirty_q[idx] <= 1'b1;
    end
  end

  // R4: an accepted write-back leaves the line clean
  assert_evict_clean_R4: assert property (@(posedge clk) disable iff (rst)
    clr_dirty |=> !dirty_q[$past(idx)]);

  // R5: an accepted refill makes the new tag resident
  assert_refill_tag_R5: assert property (@(posedge clk) disable iff (rst)
    load_tag |=> (valid_q[$past(idx)] && tag_mem[$past(idx)] == $past(tag_in)));
endmodule

// File: rtl/dmc_data.sv
module dmc_data #(
  parameter int LINES  = 16,
  parameter int WORDS  = 4,
  parameter int WORD_W = 32,
  localparam int IDX_W  = $clog2(LINES),
  localparam int OFF_W  = $clog2(WORDS),
  localparam int LINE_W = WORDS * WORD_W
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  idx,
  input  logic [OFF_W-1:0]  off,
  input  logic              wr_line_en,
  input  logic [LINE_W-1:0] wr_line,
  input  logic              wr_word_en,
  input  logic [WORD_W-1:0] wr_word,
  output logic [LINE_W-1:0] rd_line
);
  for (genvar w = 0; w < WORDS; w++) begin : g_bank
    logic [WORD_W-1:0] bank [LINES];
    logic              we;
    logic [WORD_W-1:0] wd;

    assign we = wr_line_en || (wr_word_en && off == OFF_W'(w));
    assign wd = wr_line_en ? wr_line[w*WORD_W +: WORD_W] : wr_word;

    always_ff @(posedge clk) begin
      if (we) bank[idx] <= wd;
    end

    assign rd_line[w*WORD_W +: WORD_W] = bank[idx];
  end
endmodule

// File: rtl/dmc_latency.sv
module dmc_latency #(
  parameter int HIT_DELAY = 2,
  localparam int CNT_W = $clog2(HIT_DELAY + 2)
) (
  input  logic clk,
  input  logic rst,
  input  logic step,
  output logic done
);
  logic [CNT_W-1:0] cnt_q;

  assign done = step && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= CNT_W'(HIT_DELAY);
    else if (done) cnt_q <= CNT_W'(HIT_DELAY);
    else if (step) cnt_q <= cnt_q - 1'b1;
  end

  // R7: after completion the countdown starts again from the full delay
  assert_reload_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> cnt_q == CNT_W'(HIT_DELAY));

  // R7: the counter only moves while the owner hits
  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(cnt_q));
endmodule

// File: rtl/dmc_cache.sv
module dmc_cache
  import dmc_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int LINES     = 16,
  parameter int WORDS     = 4,
  parameter int WORD_W    = 32,
  parameter int ID_W      = 2,
  parameter int HIT_DELAY = 2,
  parameter int LINE_W    = WORDS * WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ID_W-1:0]   req_id,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WORD_W-1:0] req_wword,
  input  logic [LINE_W-1:0] req_wline,
  output logic [1:0]        rsp,
  output logic [WORD_W-1:0] rsp_word,
  output logic [LINE_W-1:0] rsp_line,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LINE_W-1:0] mem_wline,
  input  logic [1:0]        mem_rsp,
  input  logic [LINE_W-1:0] mem_rline
);
  localparam int IDX_W = $clog2(LINES);
  localparam int OFF_W = $clog2(WORDS);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

  logic [OFF_W-1:0]  a_off;
  logic [IDX_W-1:0]  a_idx;
  logic [TAG_W-1:0]  a_tag;
  logic              mine, hit, dirty, done;
  logic              miss, evict, refill, mem_ok;
  logic [TAG_W-1:0]  old_tag;
  logic [LINE_W-1:0] line_q;
  op_e               op;
  rsp_e              rsp_c;

  assign a_off  = req_addr[OFF_W-1:0];
  assign a_idx  = req_addr[OFF_W +: IDX_W];
  assign a_tag  = req_addr[ADDR_W-1 -: TAG_W];
  assign op     = op_e'(req_op);

  assign miss   = mine && !hit;
  assign evict  = miss && dirty;
  assign refill = miss && !dirty;
  assign mem_ok = (mem_rsp == RSP_OK);

  dmc_owner #(.ID_W(ID_W)) u_owner (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_id(req_id),
    .done(done), .is_mine(mine)
  );

  dmc_tags #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst(rst), .idx(a_idx), .tag_in(a_tag),
    .load_tag(refill && mem_ok), .clr_dirty(evict && mem_ok),
    .set_dirty(done && (op == OP_WR_WORD || op == OP_WR_LINE)),
    .hit(hit), .dirty(dirty), .tag_out(old_tag)
  );

  dmc_data #(.LINES(LINES), .WORDS(WORDS), .WORD_W(WORD_W)) u_data (
    .clk(clk), .idx(a_idx), .off(a_off),
    .wr_line_en((refill && mem_ok) || (done && op == OP_WR_LINE)),
    .wr_line(refill ? mem_rline : req_wline),
    .wr_word_en(done && op == OP_WR_WORD),
    .wr_word(req_wword),
    .rd_line(line_q)
  );

  dmc_latency #(.HIT_DELAY(HIT_DELAY)) u_lat (
    .clk(clk), .rst(rst), .step(mine && hit), .done(done)
  );

  assign mem_req   = miss;
  assign mem_we    = evict;
  assign mem_addr  = evict ? {old_tag, a_idx, {OFF_W{1'b0}}}
                           : {a_tag,   a_idx, {OFF_W{1'b0}}};
  assign mem_wline = line_q;

  always_comb begin
    if (!mine)     rsp_c = RSP_WAIT;
    else if (miss) rsp_c = RSP_BLOCKED;
    else if (done) rsp_c = RSP_OK;
    else           rsp_c = RSP_WAIT;
  end

  assign rsp      = rsp_c;
  assign rsp_line = line_q;
  assign rsp_word = line_q[a_off*WORD_W +: WORD_W];

  // R1: nothing happens without a request
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !req_valid |-> (rsp == 2'd1 && !mem_req));

  // R2: the unused code never appears
  assert_code_range_R2: assert property (@(posedge clk) disable iff (rst)
    rsp != 2'd3);

  // R6: a pending lower-level operation is reported as blocked
  assert_pending_blocked_R6: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> rsp == 2'd2);

  // R6: an unanswered lower-level request is repeated while the owner stays
  assert_retry_R6: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ok && req_valid && $stable(req_addr)) |=>
      (!req_valid || !$stable(req_addr) || req_id != $past(req_id) || mem_req));
endmodule

// File: tb/test_dmc_cache.sv
`timescale 1ns/1ps
module test_dmc_cache;
  localparam int ADDR_W = 16, LINES = 16, WORDS = 4, WORD_W = 32, ID_W = 2, DLY = 2;
  localparam int LW = WORDS * WORD_W;

  logic          clk = 0, rst = 1;
  logic          req_valid = 0;
  logic [1:0]    req_id = 0, req_op = 0;
  logic [15:0]   req_addr = 0;
  logic [31:0]   req_wword = 0;
  logic [LW-1:0] req_wline = 0;
  logic [1:0]    rsp, mem_rsp;
  logic [31:0]   rsp_word;
  logic [LW-1:0] rsp_line, mem_wline, mem_rline;
  logic          mem_req, mem_we;
  logic [15:0]   mem_addr;

  int checks = 0, errors = 0;
  int stall_cfg = 0, stall_left = 0;
  int wr_evt = 0, wb_count = 0, rd_count = 0;
  logic [15:0]   last_wb_addr, last_rd_addr;
  logic [LW-1:0] last_wb_line;
  logic [LW-1:0] store [int];

  always #4 clk = ~clk;

  dmc_cache #(.ADDR_W(ADDR_W), .LINES(LINES), .WORDS(WORDS), .WORD_W(WORD_W),
              .ID_W(ID_W), .HIT_DELAY(DLY)) i_dmc_cache (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_id(req_id), .req_op(req_op),
    .req_addr(req_addr), .req_wword(req_wword), .req_wline(req_wline),
    .rsp(rsp), .rsp_word(rsp_word), .rsp_line(rsp_line),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wline(mem_wline),
    .mem_rsp(mem_rsp), .mem_rline(mem_rline)
  );

  function automatic logic [LW-1:0] dflt_line(input int la);
    logic [LW-1:0] l;
    for (int w = 0; w < WORDS; w++) l[w*32 +: 32] = 32'h1000_0000 + la * 16 + w;
    return l;
  endfunction

  function automatic logic [LW-1:0] mem_line(input logic [15:0] a, input int evt);
    int la = int'(a >> 2);
    if (evt >= 0 && store.exists(la)) return store[la];
    return dflt_line(la);
  endfunction

  function automatic logic [15:0] mk(input int tag, input int idx, input int off);
    return 16'((tag << 6) | (idx << 2) | off);
  endfunction

  always @* begin
    mem_rline = mem_line(mem_addr, wr_evt);
    mem_rsp   = (mem_req && stall_left == 0) ? 2'd0 : 2'd1;
  end

  always @(posedge clk) begin
    if (!mem_req) stall_left <= stall_cfg;
    else if (stall_left != 0) stall_left <= stall_left - 1;
    else begin
      stall_left <= stall_cfg;
      if (mem_we) begin
        store[int'(mem_addr >> 2)] = mem_wline;
        wr_evt++; wb_count++;
        last_wb_addr <= mem_addr; last_wb_line <= mem_wline;
      end else begin
        rd_count++; last_rd_addr <= mem_addr;
      end
    end
  end

  task automatic check(input string req, input logic [LW-1:0] act, input logic [LW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(input logic [1:0] id, input logic [1:0] op, input logic [15:0] a,
                        input logic [31:0] ww, input logic [LW-1:0] wl,
                        output int ncyc, output int nblk,
                        output logic [31:0] rw, output logic [LW-1:0] rl);
    ncyc = 0; nblk = 0; rw = 0; rl = 0;
    @(negedge clk);
    req_valid = 1; req_id = id; req_op = op; req_addr = a; req_wword = ww; req_wline = wl;
    forever begin
      #1;
      ncyc++;
      if (rsp == 2'd2) nblk++;
      if (rsp == 2'd0) begin rw = rsp_word; rl = rsp_line; break; end
      if (ncyc > 60) break;
      @(negedge clk);
    end
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic t_reset();
    @(negedge clk); #1;
    check("R1 idle rsp WAIT", LW'(rsp), LW'(2'd1));
    check("R1 no mem_req", LW'(mem_req), LW'(0));
  endtask

  task automatic t_clean_miss_and_hits();
    int n, b; logic [31:0] w; logic [LW-1:0] l; logic [LW-1:0] e;
    e = dflt_line(int'(mk(5, 3, 0) >> 2));
    access(1, 0, mk(5, 3, 1), 0, 0, n, b, w, l);
    check("R5 R6 clean miss cycles", LW'(n), LW'(4));
    check("R1 R6 clean miss blocked", LW'(b), LW'(1));
    check("R10 miss read word", LW'(w), LW'(e[32 +: 32]));
    check("R5 refill address", LW'(last_rd_addr), LW'(mk(5, 3, 0)));
    access(1, 0, mk(5, 3, 2), 0, 0, n, b, w, l);
    check("R7 hit cycles", LW'(n), LW'(DLY + 1));
    check("R10 hit read word", LW'(w), LW'(e[64 +: 32]));
    access(2, 1, mk(5, 3, 0), 0, 0, n, b, w, l);
    check("R7 reload second hit cycles", LW'(n), LW'(DLY + 1));
    check("R8 read line op", l, e);
  endtask

  task automatic t_word_write_evict();
    int n, b; logic [31:0] w; logic [LW-1:0] l, e;
    e = dflt_line(int'(mk(5, 3, 0) >> 2));
    e[64 +: 32] = 32'hDEAD_BEEF;
    access(0, 2, mk(5, 3, 2), 32'hDEAD_BEEF, 0, n, b, w, l);
    check("R9 word write hit cycles", LW'(n), LW'(DLY + 1));
    access(0, 1, mk(5, 3, 0), 0, 0, n, b, w, l);
    check("R9 word write in line", l, e);
    access(3, 0, mk(9, 3, 0), 0, 0, n, b, w, l);
    check("R4 R6 dirty miss cycles", LW'(n), LW'(5));
    check("R4 dirty miss blocked", LW'(b), LW'(2));
    check("R4 write-back address", LW'(last_wb_addr), LW'(mk(5, 3, 0)));
    check("R4 write-back line", last_wb_line, e);
    check("R5 new line word", LW'(w), LW'(32'h1000_0000 + int'(mk(9, 3, 0) >> 2) * 16));
    access(3, 0, mk(5, 3, 2), 0, 0, n, b, w, l);
    check("R4 dirty cleared, clean miss", LW'(n), LW'(4));
    check("R10 written word from memory", LW'(w), LW'(32'hDEAD_BEEF));
  endtask

  task automatic t_line_write();
    int n, b; logic [31:0] w; logic [LW-1:0] l, v;
    v = {32'h4444_0004, 32'h3333_0003, 32'h2222_0002, 32'h1111_0001};
    access(1, 3, mk(7, 6, 0), 0, v, n, b, w, l);
    check("R9 line write miss cycles", LW'(n), LW'(4));
    access(1, 0, mk(7, 6, 3), 0, 0, n, b, w, l);
    check("R9 line write word 3", LW'(w), LW'(32'h4444_0004));
    access(2, 1, mk(8, 6, 0), 0, 0, n, b, w, l);
    check("R4 line write evicted addr", LW'(last_wb_addr), LW'(mk(7, 6, 0)));
    check("R4 line write evicted data", last_wb_line, v);
  endtask

  task automatic t_stall();
    int n, b; logic [31:0] w; logic [LW-1:0] l;
    stall_cfg = 3;
    repeat (2) @(negedge clk);
    access(1, 0, mk(11, 9, 0), 0, 0, n, b, w, l);
    check("R6 stalled miss blocked", LW'(b), LW'(4));
    check("R6 stalled miss cycles", LW'(n), LW'(7));
    stall_cfg = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_owner();
    int n, b; logic [31:0] w; logic [LW-1:0] l;
    stall_cfg = 2;
    repeat (2) @(negedge clk);
    req_valid = 1; req_id = 1; req_op = 0; req_addr = mk(12, 10, 1);
    #1;
    check("R3 owner claims, blocked", LW'(rsp), LW'(2'd2));
    @(negedge clk);
    req_id = 2; req_op = 2; req_addr = mk(13, 11, 0); req_wword = 32'h5555_5555;
    #1;
    check("R3 other requester WAIT", LW'(rsp), LW'(2'd1));
    check("R3 other requester no mem_req", LW'(mem_req), LW'(0));
    @(negedge clk);
    req_valid = 0;
    stall_cfg = 0;
    access(1, 0, mk(12, 10, 1), 0, 0, n, b, w, l);
    check("R3 owner completes", LW'(w), LW'(32'h1000_0000 + int'(mk(12, 10, 0) >> 2) * 16 + 1));
    access(2, 0, mk(13, 11, 0), 0, 0, n, b, w, l);
    check("R3 ignored write left no trace", LW'(w),
          LW'(32'h1000_0000 + int'(mk(13, 11, 0) >> 2) * 16));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    t_reset();
    t_clean_miss_and_hits();
    t_word_write_evict();
    t_line_write();
    t_stall();
    t_owner();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule